// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a set of hardware lock tokens that two agents, one on a left port and one on a right port, use to agree on who controls a shared resource. Each port can ask for any token, give it back, and find out whether it currently holds it. The unit decides ownership itself. The port that asked first wins. A request that arrives while the other side holds the token waits in hardware, and it takes the token on the clock edge at which the holder gives it up.

Both ports share one clock. A port picks a token with its index, and a write strobe carries a single request or release bit. A read strobe samples that port's ownership of the indexed token into a registered read data output. Software normally requests a token, reads it back to learn whether it won, and releases the token when it has finished.

Top module: `dpsem_unit`

## Requirements
- R1: A synchronous active-high reset clears every request latch on both ports to the idle value 1, so that no token is owned. The read data outputs reset to all ones.
- R2: The unit holds 2**IDX_W tokens (eight by default), and each port selects one with its own index. A write or read on one token leaves every other token unchanged.
- R3: A write with data bit 0 equal to 0 requests the token, and one with data bit 0 equal to 1 releases it. A port that requests a free token owns it from the next clock edge.
- R4: A port that requests a token held by the other side does not get it. Its request stays pending and its reads return 1 on bit 0.
- R5: When the owner releases a token while the other side has a request pending, the token passes to the other side at that same clock edge.
- R6: The owner keeps the token until it writes a release itself, whatever writes the other port makes in the meantime.
- R7: When both ports request the same free token in the same cycle, only the left port gets it. The right request stays pending.
- R8: A pending request that is withdrawn by writing 1 no longer competes. A later release by the owner then leaves the token free.
- R9: A read strobe loads the read data register at the clock edge, using the ownership state from before that edge. Bit 0 is 0 when the port owns the token and 1 when it does not, and every higher bit is 1. Without a read strobe the register keeps its value.
- R10: Requesting a token the port already owns, or releasing one it neither owns nor requests, changes no state.
- R11: A token is never owned by both ports at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| l_idx | input | IDX_W | Left port token index |
| l_wr | input | 1 | Left port write strobe |
| l_wdata | input | 1 | Left port write bit: 0 requests, 1 releases |
| l_rd | input | 1 | Left port read strobe |
| l_rdata | output | DATA_W | Left port read data; bit 0 is 0 when the left port owns the token |
| r_idx | input | IDX_W | Right port token index |
| r_wr | input | 1 | Right port write strobe |
| r_wdata | input | 1 | Right port write bit: 0 requests, 1 releases |
| r_rd | input | 1 | Right port read strobe |
| r_rdata | output | DATA_W | Right port read data; bit 0 is 0 when the right port owns the token |

## Verification
The hardest cases to reach from the ports need a particular ordering across both ports on one token. One is a request made in the same cycle on both sides. Another is a pending request that is withdrawn before the owner releases, so that the release must leave the token free rather than hand it over. Directed sequences set up each of these orderings and then read from both sides. After that, random traffic limited to the lower four indices makes both ports collide on the same tokens often. A bench model of the latches and owners predicts every read.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Per-token state: request latches are active low (0 = requesting)
    typedef struct packed {
        logic   l_req_n;
        logic   r_req_n;
        owner_e owner;
    } tok_state_t;

    localparam tok_state_t TOK_RESET = '{l_req_n: 1'b1, r_req_n: 1'b1, owner: OWN_NONE};

endpackage

// File: rtl/dpsem_token.sv
module dpsem_token
    import dpsem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic l_wr_en,
    input  logic l_wval,
    input  logic r_wr_en,
    input  logic r_wval,
    output logic l_own,
    output logic r_own
);

    tok_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (l_wr_en) st_d.l_req_n = l_wval;
        if (r_wr_en) st_d.r_req_n = r_wval;
        unique case (st_q.owner)
            OWN_LEFT: begin
                if (st_d.l_req_n) st_d.owner = st_d.r_req_n ? OWN_NONE : OWN_RIGHT;
            end
            OWN_RIGHT: begin
                if (st_d.r_req_n) st_d.owner = st_d.l_req_n ? OWN_NONE : OWN_LEFT;
            end
            default: begin
                // free token: left wins a same-cycle tie
                if (!st_d.l_req_n)      st_d.owner = OWN_LEFT;
                else if (!st_d.r_req_n) st_d.owner = OWN_RIGHT;
                else                    st_d.owner = OWN_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= TOK_RESET;
        else     st_q <= st_d;
    end

    assign l_own = (st_q.owner == OWN_LEFT);
    assign r_own = (st_q.owner == OWN_RIGHT);

endmodule

// File: rtl/dpsem_rd_port.sv
module dpsem_rd_port #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [(1<<IDX_W)-1:0] own_vec,
    output logic [DATA_W-1:0]     rdata
);

    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d    = '1;
            rd_d[0] = ~own_vec[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '1;
        else     rd_q <= rd_d;
    end

    assign rdata = rd_q;

endmodule

// File: rtl/dpsem_unit.sv
module dpsem_unit #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic              l_wr,
    input  logic              l_wdata,
    input  logic              l_rd,
    output logic [DATA_W-1:0] l_rdata,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic              r_wr,
    input  logic              r_wdata,
    input  logic              r_rd,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int NUM_TOK = 1 << IDX_W;

    logic [NUM_TOK-1:0] l_hit, r_hit;
    logic [NUM_TOK-1:0] l_own_vec, r_own_vec;

    for (genvar t = 0; t < NUM_TOK; t++) begin : g_tok
        assign l_hit[t] = l_wr && (l_idx == IDX_W'(t));
        assign r_hit[t] = r_wr && (r_idx == IDX_W'(t));

        dpsem_token u_tok (
            .clk     (clk),
            .rst     (rst),
            .l_wr_en (l_hit[t]),
            .l_wval  (l_wdata),
            .r_wr_en (r_hit[t]),
            .r_wval  (r_wdata),
            .l_own   (l_own_vec[t]),
            .r_own   (r_own_vec[t])
        );
    end

    dpsem_rd_port #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_l (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (l_rd),
        .idx     (l_idx),
        .own_vec (l_own_vec),
        .rdata   (l_rdata)
    );

    dpsem_rd_port #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_r (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (r_rd),
        .idx     (r_idx),
        .own_vec (r_own_vec),
        .rdata   (r_rdata)
    );

endmodule

// File: rtl/dpsem_chk.sv
module dpsem_chk #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [IDX_W-1:0]      l_idx,
    input logic                  l_wr,
    input logic                  l_wdata,
    input logic                  l_rd,
    input logic [DATA_W-1:0]     l_rdata,
    input logic [IDX_W-1:0]      r_idx,
    input logic                  r_wr,
    input logic                  r_wdata,
    input logic                  r_rd,
    input logic [DATA_W-1:0]     r_rdata,
    input logic [(1<<IDX_W)-1:0] l_own_vec,
    input logic [(1<<IDX_W)-1:0] r_own_vec
);

    localparam int NUM_TOK = 1 << IDX_W;

    // R11
    excl_own_chk: assert property (@(posedge clk) disable iff (rst)
        (l_own_vec & r_own_vec) == '0);

    // R1
    reset_free_chk: assert property (@(posedge clk)
        $past(rst) |-> ((l_own_vec | r_own_vec) == '0));

    // R9
    l_read_chk: assert property (@(posedge clk) disable iff (rst)
        l_rd |=> (l_rdata[0] == !$past(l_own_vec[l_idx])));

    // R9
    r_read_chk: assert property (@(posedge clk) disable iff (rst)
        r_rd |=> (r_rdata[0] == !$past(r_own_vec[r_idx])));

    for (genvar t = 0; t < NUM_TOK; t++) begin : g_tok_chk
        // R6
        l_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (l_own_vec[t] && !(l_wr && l_idx == IDX_W'(t) && l_wdata)) |=> l_own_vec[t]);
        // R6
        r_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (r_own_vec[t] && !(r_wr && r_idx == IDX_W'(t) && r_wdata)) |=> r_own_vec[t]);
        // R3
        l_grant_chk: assert property (@(posedge clk) disable iff (rst)
            (l_wr && l_idx == IDX_W'(t) && !l_wdata && !l_own_vec[t] && !r_own_vec[t])
            |=> l_own_vec[t]);
    end

endmodule

bind dpsem_unit dpsem_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .l_idx     (l_idx),
    .l_wr      (l_wr),
    .l_wdata   (l_wdata),
    .l_rd      (l_rd),
    .l_rdata   (l_rdata),
    .r_idx     (r_idx),
    .r_wr      (r_wr),
    .r_wdata   (r_wdata),
    .r_rd      (r_rd),
    .r_rdata   (r_rdata),
    .l_own_vec (l_own_vec),
    .r_own_vec (r_own_vec)
);

// File: tb/tb_dpsem_unit.sv
`timescale 1ns/1ps
module tb_dpsem_unit;

    localparam int IDX_W  = 3;
    localparam int DATA_W = 16;
    localparam int NT     = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst;
    logic [IDX_W-1:0]  l_idx, r_idx;
    logic              l_wr, l_wdata, l_rd, r_wr, r_wdata, r_rd;
    logic [DATA_W-1:0] l_rdata, r_rdata;

    always #2 clk = ~clk;

    dpsem_unit #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dut (.*);

    int tests = 0;
    int fails = 0;

    // bench model: latches 1 = idle, owner 0 none / 1 left / 2 right
    logic m_lq [NT];
    logic m_rq [NT];
    int   m_own [NT];
    logic [DATA_W-1:0] exp_l, exp_r;

    function automatic logic [DATA_W-1:0] rd_word(input logic owns);
        logic [DATA_W-1:0] w;
        w = '1;
        w[0] = !owns;
        return w;
    endfunction

    function automatic int next_owner(input int cur, input logic lq, input logic rq);
        if (cur == 1) return lq ? (rq ? 0 : 2) : 1;
        if (cur == 2) return rq ? (lq ? 0 : 1) : 2;
        if (!lq) return 1;
        if (!rq) return 2;
        return 0;
    endfunction

    task automatic check(input string req, input string port,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s port %s: actual %h expected %h", req, port, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NT; i++) begin
            m_lq[i] = 1'b1; m_rq[i] = 1'b1; m_own[i] = 0;
        end
        exp_l = '1; exp_r = '1;
    endtask

    // one cycle: drive after negedge, model update, sample after posedge
    task automatic cyc(input string req,
                       input logic lw, input int li, input logic ld, input logic lr,
                       input logic rw, input int ri, input logic rd, input logic rr);
        l_wr = lw; l_idx = IDX_W'(li); l_wdata = ld; l_rd = lr;
        r_wr = rw; r_idx = IDX_W'(ri); r_wdata = rd; r_rd = rr;
        if (lr) exp_l = rd_word(m_own[li] == 1);
        if (rr) exp_r = rd_word(m_own[ri] == 2);
        if (lw) m_lq[li] = ld;
        if (rw) m_rq[ri] = rd;
        for (int i = 0; i < NT; i++) m_own[i] = next_owner(m_own[i], m_lq[i], m_rq[i]);
        @(posedge clk); #1;
        check(req, "L", l_rdata, exp_l);
        check(req, "R", r_rdata, exp_r);
        @(negedge clk);
    endtask

    task automatic lwrite(input string q, input int i, input logic d); cyc(q, 1, i, d, 0, 0, 0, 0, 0); endtask
    task automatic rwrite(input string q, input int i, input logic d); cyc(q, 0, 0, 0, 0, 1, i, d, 0); endtask
    task automatic bread (input string q, input int li, input int ri); cyc(q, 0, li, 0, 1, 0, ri, 0, 1); endtask
    task automatic idle  (input string q);                            cyc(q, 0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        l_wr = 0; l_idx = '0; l_wdata = 1; l_rd = 0;
        r_wr = 0; r_idx = '0; r_wdata = 1; r_rd = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: outputs all ones, every token free from both sides
        idle("R1");
        for (int i = 0; i < NT; i++) bread("R1", i, NT - 1 - i);

        // R3: left claims token 3
        lwrite("R3", 3, 0);
        bread("R3", 3, 3);
        // R4: right contends, stays pending and reads 1
        rwrite("R4", 3, 0);
        bread("R4", 3, 3);
        // R6: right writes again, left keeps
        rwrite("R6", 3, 0);
        rwrite("R6", 3, 0);
        bread("R6", 3, 3);
        // R5: left release hands over to pending right
        lwrite("R5", 3, 1);
        bread("R5", 3, 3);
        // R8: left pends then withdraws; right release leaves token free
        lwrite("R8", 3, 0);
        lwrite("R8", 3, 1);
        rwrite("R8", 3, 1);
        bread("R8", 3, 3);
        // R7: same-cycle requests on token 5
        cyc("R7", 1, 5, 0, 0, 1, 5, 0, 0);
        bread("R7", 5, 5);
        lwrite("R7", 5, 1);
        bread("R7", 5, 5);
        rwrite("R7", 5, 1);
        bread("R7", 5, 5);
        // R10: redundant request, stray release
        lwrite("R10", 6, 0);
        lwrite("R10", 6, 0);
        rwrite("R10", 6, 1);
        bread("R10", 6, 6);
        lwrite("R10", 6, 1);
        lwrite("R10", 6, 1);
        bread("R10", 6, 6);
        // R2: independent tokens
        cyc("R2", 1, 0, 0, 0, 1, 7, 0, 0);
        for (int i = 0; i < NT; i++) bread("R2", i, i);
        // R9: no read strobe keeps register
        lwrite("R9", 0, 1);
        idle("R9");
        bread("R9", 0, 0);
        rwrite("R9", 7, 1);

        // random traffic concentrated on four tokens
        void'($urandom(32'h5eed_0017));
        for (int n = 0; n < 3000; n++) begin
            cyc("R11",
                ($urandom % 3) == 0, $urandom % 4, $urandom % 2, ($urandom % 2) == 0,
                ($urandom % 3) == 0, $urandom % 4, $urandom % 2, ($urandom % 2) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule